// File: doc/BRIEF.md
# Cascadable Segment Column Data Loader

This block collects one display line of column bits from a narrow parallel bus and holds it for the display output stage. A mode input sets the bus width. In byte mode every capture strobe delivers eight columns. In nibble mode the low four bus lanes are sampled twice, and the two samples are joined into one byte before it is written. A direction input sets the fill order, either from the top column down or from column 1 up. In the upward order the lanes within each group are reversed. Once the line is complete, a line-latch strobe copies the whole column store into the line register in one cycle.

Several identical loaders can share one bus and fill in turn. After a line-latch strobe, a loader waits for its enable input to go low. At that point it selects itself and stays selected, even after the enable input returns high. It takes exactly one line of bits and then deselects. At the moment it deselects, its enable output goes low for one capture period, and that output selects the next loader in the chain. The two enable pins swap their roles with the direction input.

Each column drives a 2-bit level code. The code is chosen from the latched bit and the frame-inversion input. A low display-enable input forces every column to the lowest level code and clears the line register. Bus capture continues while the display is off. Capture and latch events arrive as single-cycle strobes, each marking a falling edge, on one synchronous clock.

Top module: `seg_col_loader`

## Requirements
- R1: With `bus_4b` low (byte mode) all eight lanes are captured on each strobe, so a line of NCOL columns takes NCOL/8 strobes.
- R2: With `bus_4b` high (nibble mode) only lanes 3..0 are sampled, and lanes 7..4 are ignored. Two consecutive samples form one byte: the first sample becomes the upper nibble and the second the lower nibble. A line takes NCOL/4 strobes.
- R3: With `dir_up` low, byte k of the line fills columns NCOL-8k-7 to NCOL-8k, with byte bit i on column NCOL-8k-7+i. Column c is bit c-1 of the line.
- R4: With `dir_up` high, byte k fills columns 8k+1 to 8k+8 with the lanes reversed: byte bit 7 goes to column 8k+1 and byte bit 0 to column 8k+8.
- R5: With `dir_up` low, pin A is the enable output (`cas_a_oe`=1, `cas_b_oe`=0) and pin B is the enable input. With `dir_up` high the roles swap.
- R6: A line-latch strobe resets the fill position and deselects the block. Capture starts on a strobe while the enable input is low, and selection then holds until NCOL bits are taken. Strobes while deselected leave the column store unchanged.
- R7: The enable output rests high. After the strobe that completes the line it is low until the next capture strobe, and that strobe returns it high.
- R8: On a line-latch strobe all NCOL stored bits enter the line register together. Capture strobes alone do not change the line register.
- R9: While `disp_on` is low every column code is 00, the line register is held cleared, and bus capture into the column store goes on.
- R10: With `disp_on` high the code for (frame, bit) is (0,0)→01, (0,1)→00, (1,0)→10, (1,1)→11. Codes are registered, so they follow their inputs one clock later.
- R11: After reset every column code is 00, both enable outputs are high, and the column store and line register are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_stb | input | 1 | Capture strobe, one cycle per falling edge of the data clock |
| lat_stb | input | 1 | Line-latch strobe, one cycle per falling edge of the latch pulse |
| bus_d | input | WORD_W | Parallel column data |
| bus_4b | input | 1 | 1: nibble capture on lanes 3..0; 0: byte capture |
| dir_up | input | 1 | 1: fill from column 1 upward; 0: fill from column NCOL downward |
| disp_on | input | 1 | Low forces all columns to the lowest level |
| frame_inv | input | 1 | Frame-inversion input |
| cas_a_in | input | 1 | Pin A input value (enable input when dir_up=1) |
| cas_b_in | input | 1 | Pin B input value (enable input when dir_up=0) |
| cas_a_out | output | 1 | Pin A output value (enable output) |
| cas_a_oe | output | 1 | Pin A drives when 1 |
| cas_b_out | output | 1 | Pin B output value (enable output) |
| cas_b_oe | output | 1 | Pin B drives when 1 |
| lvl_code | output | 2*NCOL | Level code per column, column c at bits 2c-1..2c-2 |

## Verification
The bench builds the loader with NCOL=24 and WORD_W=8, so a line is three groups. A full line then takes three byte strobes or six nibble strobes, and it can be written out by hand for all four width and direction combinations. The short line puts the final-group handoff, the one-period enable pulse and the deselected-strobe case within a few cycles of each other. The display-off and mid-line latch corners can therefore be checked against hand-computed patterns.

// File: rtl/slc_pkg.sv
package slc_pkg;

  typedef enum logic [1:0] {
    LVL_LOW   = 2'b00,
    LVL_MIDLO = 2'b01,
    LVL_MIDHI = 2'b10,
    LVL_HIGH  = 2'b11
  } lvl_e;

  // level chosen from frame phase and latched column bit
  function automatic lvl_e lvl_pick(input logic fr, input logic b);
    case ({fr, b})
      2'b00:   return LVL_MIDLO;
      2'b01:   return LVL_LOW;
      2'b10:   return LVL_MIDHI;
      default: return LVL_HIGH;
    endcase
  endfunction

endpackage

// File: rtl/slc_word_asm.sv
module slc_word_asm #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              take,
  input  logic              bus_4b,
  input  logic [WORD_W-1:0] bus_d,
  output logic              word_vld,
  output logic [WORD_W-1:0] word
);
  localparam int HALF = WORD_W / 2;

  logic            half_q;
  logic [HALF-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      half_q <= 1'b0;
      hold_q <= '0;
    end else if (take && bus_4b) begin
      if (!half_q) begin
        hold_q <= bus_d[HALF-1:0];
        half_q <= 1'b1;
      end else begin
        half_q <= 1'b0;
      end
    end
  end

  always_comb begin
    word_vld = take && (!bus_4b || half_q);
    word     = bus_4b ? {hold_q, bus_d[HALF-1:0]} : bus_d;
  end
endmodule

// File: rtl/slc_fill_ctl.sv
module slc_fill_ctl #(
  parameter int NGRP = 30,
  parameter int CW   = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          cap,
  input  logic          ein_n,
  input  logic          word_vld,
  output logic          take,
  output logic [CW-1:0] grp_idx,
  output logic          sel,
  output logic          done,
  output logic          eo_n
);
  logic [CW-1:0] cnt_q;
  logic          sel_q, done_q, eo_q;
  logic          last;

  always_comb begin
    take    = cap && !clr && !done_q && (sel_q || !ein_n);
    last    = (cnt_q == CW'(NGRP - 1));
    grp_idx = cnt_q;
    sel     = sel_q;
    done    = done_q;
    eo_n    = eo_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q  <= '0;
      sel_q  <= 1'b0;
      done_q <= 1'b0;
      eo_q   <= 1'b1;
    end else begin
      if (take) sel_q <= 1'b1;
      if (word_vld) begin
        if (last) begin
          cnt_q  <= '0;
          sel_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (word_vld && last) eo_q <= 1'b0;
      else if (cap)         eo_q <= 1'b1;
    end
  end
endmodule

// File: rtl/slc_col_store.sv
module slc_col_store #(
  parameter int NCOL   = 240,
  parameter int WORD_W = 8,
  parameter int NGRP   = 30,
  parameter int CW     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              disp_on,
  input  logic              lat,
  input  logic              dir_up,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word,
  input  logic [CW-1:0]     grp_idx,
  output logic [NCOL-1:0]   col,
  output logic [NCOL-1:0]   line
);
  logic [WORD_W-1:0] wrev, wdat;
  logic [CW-1:0]     tgt;
  logic [NCOL-1:0]   col_q, line_q;

  for (genvar b = 0; b < WORD_W; b++) begin : g_rev
    assign wrev[b] = word[WORD_W-1-b];
  end

  always_comb begin
    wdat = dir_up ? wrev : word;
    tgt  = dir_up ? grp_idx : (CW'(NGRP - 1) - grp_idx);
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    always_ff @(posedge clk) begin
      if (rst)
        col_q[g*WORD_W +: WORD_W] <= '0;
      else if (word_vld && (tgt == CW'(g)))
        col_q[g*WORD_W +: WORD_W] <= wdat;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !disp_on) line_q <= '0;
    else if (lat)        line_q <= col_q;
  end

  assign col  = col_q;
  assign line = line_q;
endmodule

// File: rtl/slc_level_map.sv
module slc_level_map
  import slc_pkg::*;
#(
  parameter int NCOL = 240
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              disp_on,
  input  logic              frame_inv,
  input  logic [NCOL-1:0]   line,
  output logic [2*NCOL-1:0] lvl
);
  for (genvar c = 0; c < NCOL; c++) begin : g_col
    always_ff @(posedge clk) begin
      if (rst || !disp_on) lvl[2*c +: 2] <= LVL_LOW;
      else                 lvl[2*c +: 2] <= lvl_pick(frame_inv, line[c]);
    end
  end
endmodule

// File: rtl/seg_col_loader.sv
module seg_col_loader #(
  parameter int NCOL   = 240,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_stb,
  input  logic              lat_stb,
  input  logic [WORD_W-1:0] bus_d,
  input  logic              bus_4b,
  input  logic              dir_up,
  input  logic              disp_on,
  input  logic              frame_inv,
  input  logic              cas_a_in,
  input  logic              cas_b_in,
  output logic              cas_a_out,
  output logic              cas_a_oe,
  output logic              cas_b_out,
  output logic              cas_b_oe,
  output logic [2*NCOL-1:0] lvl_code
);
  localparam int NGRP = NCOL / WORD_W;
  localparam int CW   = (NGRP > 1) ? $clog2(NGRP) : 1;

  logic              ein_n, take, word_vld, sel_w, done_w, eo_n;
  logic [WORD_W-1:0] word;
  logic [CW-1:0]     grp_idx;
  logic [NCOL-1:0]   col_w, line_w;

  assign ein_n = dir_up ? cas_a_in : cas_b_in;

  slc_fill_ctl #(.NGRP(NGRP), .CW(CW)) u_fill (
    .clk(clk), .rst(rst), .clr(lat_stb), .cap(cap_stb), .ein_n(ein_n),
    .word_vld(word_vld), .take(take), .grp_idx(grp_idx),
    .sel(sel_w), .done(done_w), .eo_n(eo_n)
  );

  slc_word_asm #(.WORD_W(WORD_W)) u_asm (
    .clk(clk), .rst(rst), .clr(lat_stb), .take(take), .bus_4b(bus_4b),
    .bus_d(bus_d), .word_vld(word_vld), .word(word)
  );

  slc_col_store #(.NCOL(NCOL), .WORD_W(WORD_W), .NGRP(NGRP), .CW(CW)) u_store (
    .clk(clk), .rst(rst), .disp_on(disp_on), .lat(lat_stb), .dir_up(dir_up),
    .word_vld(word_vld), .word(word), .grp_idx(grp_idx),
    .col(col_w), .line(line_w)
  );

  slc_level_map #(.NCOL(NCOL)) u_lvl (
    .clk(clk), .rst(rst), .disp_on(disp_on), .frame_inv(frame_inv),
    .line(line_w), .lvl(lvl_code)
  );

  assign cas_a_oe  = !dir_up;
  assign cas_b_oe  = dir_up;
  assign cas_a_out = eo_n;
  assign cas_b_out = eo_n;
endmodule

// File: rtl/slc_chk.sv
module slc_chk #(
  parameter int NCOL = 240
) (
  input logic              clk,
  input logic              rst,
  input logic              cap,
  input logic              lat,
  input logic              disp_on,
  input logic              eo_n,
  input logic              word_vld,
  input logic              sel,
  input logic              done,
  input logic [NCOL-1:0]   col,
  input logic [NCOL-1:0]   line,
  input logic [2*NCOL-1:0] lvl
);
  p_eo_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!eo_n && !cap && !lat) |=> !eo_n);
  p_eo_one_period_r7: assert property (@(posedge clk) disable iff (rst)
    (!eo_n && cap) |=> eo_n);
  p_eo_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(eo_n) |-> ($past(word_vld) && done));
  p_ignore_deselected_r6: assert property (@(posedge clk) disable iff (rst)
    (done && !lat) |=> $stable(col));
  p_sel_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(sel && done));
  p_line_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!lat && disp_on) |=> $stable(line));
  p_off_clears_r9: assert property (@(posedge clk) disable iff (rst)
    !disp_on |=> (line == '0));
  p_off_lowest_r9: assert property (@(posedge clk) disable iff (rst)
    !disp_on |=> (lvl == '0));
endmodule

bind seg_col_loader slc_chk #(.NCOL(NCOL)) u_chk (
  .clk(clk), .rst(rst), .cap(cap_stb), .lat(lat_stb), .disp_on(disp_on),
  .eo_n(eo_n), .word_vld(word_vld), .sel(sel_w), .done(done_w),
  .col(col_w), .line(line_w), .lvl(lvl_code)
);

// File: tb/seg_col_loader_bench.sv
module seg_col_loader_bench;
  localparam int CLK_P = 10;
  localparam int NC    = 24;
  localparam int NV    = 4;
  // {bus_4b, dir_up, s0..s5, expected columns (bit c-1 = column c)}
  localparam logic [73:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'hA5, 8'h3C, 8'h81, 8'h00, 8'h00, 8'h00, 24'hA53C81},
    {1'b0, 1'b1, 8'h01, 8'h12, 8'hF0, 8'h00, 8'h00, 8'h00, 24'h0F4880},
    {1'b1, 1'b0, 8'hF1, 8'h72, 8'h03, 8'hE4, 8'h55, 8'h96, 24'h123456},
    {1'b1, 1'b1, 8'hA9, 8'h5C, 8'hF1, 8'h30, 8'h07, 8'hCE, 24'h7E0839}
  };

  logic clk = 0, rst = 1, cap_stb = 0, lat_stb = 0;
  logic [7:0] bus_d = '0;
  logic bus_4b = 0, dir_up = 0, disp_on = 1, frame_inv = 1;
  logic cas_a_in = 1, cas_b_in = 1;
  logic cas_a_out, cas_a_oe, cas_b_out, cas_b_oe;
  logic [2*NC-1:0] lvl_code;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  seg_col_loader #(.NCOL(NC), .WORD_W(8)) u_seg_col_loader (
    .clk(clk), .rst(rst), .cap_stb(cap_stb), .lat_stb(lat_stb), .bus_d(bus_d),
    .bus_4b(bus_4b), .dir_up(dir_up), .disp_on(disp_on), .frame_inv(frame_inv),
    .cas_a_in(cas_a_in), .cas_b_in(cas_b_in), .cas_a_out(cas_a_out),
    .cas_a_oe(cas_a_oe), .cas_b_out(cas_b_out), .cas_b_oe(cas_b_oe),
    .lvl_code(lvl_code)
  );

  function automatic logic [2*NC-1:0] lvl_exp(logic [NC-1:0] b, logic fr, logic on);
    logic [2*NC-1:0] r;
    for (int c = 0; c < NC; c++) begin
      if (!on)     r[2*c +: 2] = 2'b00;
      else if (fr) r[2*c +: 2] = {1'b1, b[c]};
      else         r[2*c +: 2] = b[c] ? 2'b00 : 2'b01;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [7:0] d);
    @(negedge clk); cap_stb = 1; bus_d = d;
    @(negedge clk); cap_stb = 0;
  endtask

  task automatic latch_line();
    @(negedge clk); lat_stb = 1;
    @(negedge clk); lat_stb = 0;
    @(negedge clk);
  endtask

  task automatic set_ein(input logic v);
    if (dir_up) cas_a_in = v; else cas_b_in = v;
  endtask

  task automatic chk_lvl(input string req, input logic [NC-1:0] b);
    logic [2*NC-1:0] e;
    e = lvl_exp(b, frame_inv, disp_on);
    chk(lvl_code == e, req, 64'(lvl_code), 64'(e));
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    repeat (2) @(negedge clk);
    chk(lvl_code == '0, "R11 codes", 64'(lvl_code), 64'(0));
    chk(cas_a_out && cas_b_out, "R11 enable out", {62'b0, cas_a_out, cas_b_out}, 64'h3);
    rst = 0; frame_inv = 0;
    @(negedge clk);
    chk_lvl("R11 cleared line", '0);
    frame_inv = 1;

    // table walk: R1 R2 R3 R4 R5 R7 R10
    for (int v = 0; v < NV; v++) begin
      logic [7:0] s [6];
      logic [NC-1:0] ex;
      int n;
      bus_4b = VEC[v][73]; dir_up = VEC[v][72];
      for (int i = 0; i < 6; i++) s[i] = VEC[v][71-8*i -: 8];
      ex = VEC[v][23:0];
      n  = bus_4b ? 6 : 3;
      latch_line();
      chk(cas_a_oe == !dir_up && cas_b_oe == dir_up, "R5 pin roles",
          {62'b0, cas_a_oe, cas_b_oe}, {62'b0, !dir_up, dir_up});
      for (int i = 0; i < n; i++) begin
        if (i == 0) set_ein(0);
        strobe(s[i]);
        if (i == 0) set_ein(1);
        chk(cas_a_out == (i != n-1), "R7 enable out after strobe",
            64'(cas_a_out), 64'(i != n-1));
      end
      repeat (2) @(negedge clk);
      chk(!cas_a_out, "R7 held low until next strobe", 64'(cas_a_out), 64'(0));
      strobe(8'hFF);
      chk(cas_a_out, "R7 high after one period", 64'(cas_a_out), 64'(1));
      latch_line();
      chk_lvl(bus_4b ? (dir_up ? "R2 R4 R6 fill" : "R2 R3 R6 fill")
                     : (dir_up ? "R1 R4 R6 fill" : "R1 R3 R6 fill"), ex);
    end

    // R10: frame low levels
    frame_inv = 0;
    @(negedge clk); @(negedge clk);
    chk_lvl("R10 frame low", 24'h7E0839);

    // R6: no enable, strobes ignored
    latch_line();
    repeat (6) strobe(8'h00);
    chk(cas_a_out && cas_b_out, "R6 no handoff when unselected", 64'(cas_a_out), 64'(1));
    latch_line();
    chk_lvl("R6 unselected strobes ignored", 24'h7E0839);

    // R8: capture alone leaves line unchanged
    bus_4b = 0; dir_up = 0; frame_inv = 1;
    latch_line();
    set_ein(0); strobe(8'h11); set_ein(1);
    @(negedge clk);
    chk_lvl("R8 line unchanged by capture", 24'h7E0839);
    strobe(8'h22); strobe(8'h44);

    // R9: display off
    disp_on = 0;
    @(negedge clk);
    chk_lvl("R9 all lowest", '0);
    latch_line();
    set_ein(0); strobe(8'h12); set_ein(1);
    strobe(8'h34); strobe(8'h56);
    chk_lvl("R9 still lowest during capture", '0);
    disp_on = 1;
    @(negedge clk); @(negedge clk);
    chk_lvl("R9 line cleared", '0);
    latch_line();
    chk_lvl("R9 capture kept while off", 24'h123456);

    // R6: latch strobe mid-line resets fill position
    latch_line();
    set_ein(0); strobe(8'hFF); set_ein(1);
    latch_line();
    chk_lvl("R6 partial line", 24'hFF3456);
    set_ein(0); strobe(8'h01); set_ein(1);
    strobe(8'h02); strobe(8'h03);
    chk(!cas_a_out, "R7 handoff after restarted line", 64'(cas_a_out), 64'(0));
    latch_line();
    chk_lvl("R6 restart from first group", 24'h010203);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule